// File: doc/BRIEF.md
# Six-Step Three-Phase Bridge Sequencer

This block walks a three-phase, two-level inverter bridge through a fixed cycle of six active switching patterns. Each pulse on the step input moves the pattern one position forward, or one position backward when the reverse input is set. Consecutive patterns differ in exactly one leg, so the voltage vector turns in 60° steps and the bridge never rests in a state where all upper or all lower switches conduct.

Each leg drives a complementary pair of gate signals. When a leg changes state, the gate that must turn off drops at once. The gate that must turn on is held back by a dead time, set in clock cycles on an input port. While enable is low, every gate is off and the pattern position returns to the first pattern. The step rate, amplitude control and the power stage sit outside this block.

Top module: `sixstep_bridge_seq`

## Requirements
- R1: The upper and lower gate of one leg are never high in the same cycle.
- R2: After reset and while enabled, `leg_state` never shows 3'b000 or 3'b111. After reset it shows 3'b100.
- R3: With `leg_state[2]` = leg A, `[1]` = leg B and `[0]` = leg C, forward stepping visits 100, 110, 010, 011, 001, 101 and then returns to 100.
- R4: A step is taken at the rising edge where `enable` and `step_tick` are both high. `leg_state` shows the new pattern right after that edge.
- R5: With `reverse` high, each step moves one position backward through the R3 order. From 100 the next pattern is 101.
- R6: Every step changes exactly one bit of `leg_state`.
- R7: When a leg changes, both of its gates are low from the moment `leg_state` changes. The gate matching the new state goes high after `dead_time`+1 further rising edges. Gates of unchanged legs stay as they were.
- R8: With `enable` low, all six gates are low at once. The pattern returns to 100 at the next edge, and step ticks are ignored. After `enable` rises, each leg's matching gate goes high at the (`dead_time`+1)th rising edge.
- R9: Asynchronous active-low reset forces all gates low and `leg_state` to 100 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable. Low turns all gates off and rewinds the pattern |
| step_tick | input | 1 | One-cycle pulse that advances the pattern |
| reverse | input | 1 | High selects backward stepping |
| dead_time | input | DT_W | Turn-on delay in clock cycles |
| leg_state | output | 3 | Commanded leg states, A in bit 2, 1 = upper on |
| gate_hi | output | 3 | Upper switch gates, leg A in bit 2 |
| gate_lo | output | 3 | Lower switch gates, leg A in bit 2 |

## Verification
`leg_state` is due right after the edge that samples the tick, so the bench drives the tick at a falling edge and reads `leg_state` at the next falling edge. Gates that turn off are read in that same sample. Gates that turn on are read at every following falling edge: they must stay low through `dead_time` samples and be high at sample `dead_time`+1. The same count is used after enable rises. Turn-off on disable and on reset is read one nanosecond after the input changes, before any edge.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    localparam int unsigned NUM_LEGS  = 3;
    localparam int unsigned NUM_STEPS = 6;
    localparam int unsigned IDX_W     = $clog2(NUM_STEPS);

    typedef logic [NUM_LEGS-1:0] leg_vec_t;
    typedef logic [IDX_W-1:0]    step_idx_t;

    // Pattern per position: bit2 = leg A, bit1 = leg B, bit0 = leg C.
    function automatic leg_vec_t step_pattern(input step_idx_t idx);
        leg_vec_t p;
        case (idx)
            3'd0:    p = 3'b100;
            3'd1:    p = 3'b110;
            3'd2:    p = 3'b010;
            3'd3:    p = 3'b011;
            3'd4:    p = 3'b001;
            3'd5:    p = 3'b101;
            default: p = 3'b100;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sixstep_index_ctr.sv
module sixstep_index_ctr
    import sixstep_pkg::*;
#(
    parameter int unsigned STEPS = NUM_STEPS
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      step_tick,
    input  logic      reverse,
    output step_idx_t idx_o
);

    localparam step_idx_t LAST = step_idx_t'(STEPS - 1);

    typedef struct packed {
        step_idx_t idx;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.idx = '0;
        end else if (step_tick) begin
            if (reverse) begin
                st_d.idx = (st_q.idx == '0) ? LAST : st_q.idx - 1'b1;
            end else begin
                st_d.idx = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;

    // R3: position stays inside the six-entry cycle
    assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= LAST);

    // R8: a tick while disabled does not move the position away from the first one
    assert_tick_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && step_tick) |=> (idx_o == '0));

endmodule

// File: rtl/sixstep_leg_driver.sv
module sixstep_leg_driver #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            leg,
    input  logic [DT_W-1:0] dead_time,
    output logic            gate_hi,
    output logic            gate_lo
);

    typedef struct packed {
        logic            armed;
        logic            last;
        logic [DT_W-1:0] wait_cnt;
    } drv_state_t;

    drv_state_t st_d, st_q;
    logic       settled;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.armed    = 1'b0;
            st_d.last     = 1'b0;
            st_d.wait_cnt = '0;
        end else if (!st_q.armed || (leg != st_q.last)) begin
            st_d.armed    = 1'b1;
            st_d.last     = leg;
            st_d.wait_cnt = dead_time;
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A gate is on only when the leg has held its value through the dead time.
    assign settled = enable && st_q.armed && (st_q.wait_cnt == '0);
    assign gate_hi = settled &&  st_q.last &&  leg;
    assign gate_lo = settled && !st_q.last && !leg;

    // R1: complementary gates never overlap
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R7: a leg change turns both gates off in the cycle it is seen
    assert_change_blanks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (leg != $past(leg))) |-> (!gate_hi && !gate_lo));

    // R7: a turn-on is always preceded by a cycle with the opposite gate off
    assert_gap_before_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(!gate_lo));

    assert_gap_before_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(!gate_hi));

    // R8: no gate while disabled
    assert_off_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!gate_hi && !gate_lo));

endmodule

// File: rtl/sixstep_bridge_seq.sv
module sixstep_bridge_seq
    import sixstep_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                step_tick,
    input  logic                reverse,
    input  logic [DT_W-1:0]     dead_time,
    output logic [NUM_LEGS-1:0] leg_state,
    output logic [NUM_LEGS-1:0] gate_hi,
    output logic [NUM_LEGS-1:0] gate_lo
);

    step_idx_t pos;

    sixstep_index_ctr #(
        .STEPS(NUM_STEPS)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .step_tick(step_tick),
        .reverse  (reverse),
        .idx_o    (pos)
    );

    assign leg_state = step_pattern(pos);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        sixstep_leg_driver #(
            .DT_W(DT_W)
        ) u_drv (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (enable),
            .leg      (leg_state[g]),
            .dead_time(dead_time),
            .gate_hi  (gate_hi[g]),
            .gate_lo  (gate_lo[g])
        );
    end

    // R2: zero states never appear
    assert_no_zero_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_state != 3'b000) && (leg_state != 3'b111));

    // R6: at most one leg moves between consecutive cycles while running
    assert_single_leg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($countones(leg_state ^ $past(leg_state)) <= 1));

endmodule

// File: tb/sixstep_bridge_seq_tb.sv
module sixstep_bridge_seq_tb;

    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            enable;
    logic            step_tick;
    logic            reverse;
    logic [DT_W-1:0] dead_time;
    logic [2:0]      leg_state;
    logic [2:0]      gate_hi;
    logic [2:0]      gate_lo;

    int errors = 0;
    int checks = 0;
    int pos    = 0;

    always #10 clk = ~clk;

    sixstep_bridge_seq #(.DT_W(DT_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .step_tick(step_tick),
        .reverse  (reverse),
        .dead_time(dead_time),
        .leg_state(leg_state),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    // Expected pattern from the position, {A,B,C}
    function automatic logic [2:0] exp_pat(input int i);
        logic a, b, c;
        a = (i == 0) || (i == 1) || (i == 5);
        b = (i >= 1) && (i <= 3);
        c = (i >= 3) && (i <= 5);
        return {a, b, c};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        chk("R9 gate_hi at reset", {5'b0, gate_hi}, 8'h00);
        chk("R9 gate_lo at reset", {5'b0, gate_lo}, 8'h00);
        chk("R9 leg_state at reset", {5'b0, leg_state}, 8'h04);
        chk("R2 reset pattern", {5'b0, leg_state}, 8'h04);
        @(negedge clk);
        rst_n = 1'b1;
        pos = 0;
    endtask

    task automatic start_run(input int d);
        @(negedge clk);
        dead_time = DT_W'(d);
        enable    = 1'b1;
        pos       = 0;
        for (int c = 0; c <= d + 1; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            chk("R8 enable start gate_hi", {5'b0, gate_hi}, (c == d + 1) ? 8'h04 : 8'h00);
            chk("R8 enable start gate_lo", {5'b0, gate_lo}, (c == d + 1) ? 8'h03 : 8'h00);
        end
    endtask

    task automatic do_step(input bit rev, input int d);
        logic [2:0] prv, nw, chg, ehi, elo;
        @(negedge clk);
        reverse   = rev;
        step_tick = 1'b1;
        prv = exp_pat(pos);
        pos = rev ? (pos + 5) % 6 : (pos + 1) % 6;
        nw  = exp_pat(pos);
        chg = prv ^ nw;
        @(negedge clk);
        step_tick = 1'b0;
        #1;
        chk(rev ? "R5 reverse pattern" : "R3 forward pattern", {5'b0, leg_state}, {5'b0, nw});
        chk("R4 step taken once", {5'b0, leg_state}, {5'b0, nw});
        chk("R6 one leg changes", 8'($countones(prv ^ leg_state)), 8'd1);
        chk("R2 no zero state", {7'b0, (leg_state == 3'b000) || (leg_state == 3'b111)}, 8'h00);
        for (int c = 0; c <= d + 1; c++) begin
            if (c > 0) begin
                @(negedge clk);
                #1;
            end
            ehi = (nw & ~chg)  | ((c == d + 1) ? (nw & chg)  : 3'b000);
            elo = (~nw & ~chg) | ((c == d + 1) ? (~nw & chg) : 3'b000);
            chk("R7 gate_hi timing", {5'b0, gate_hi}, {5'b0, ehi});
            chk("R7 gate_lo timing", {5'b0, gate_lo}, {5'b0, elo});
            chk("R1 no overlap", {5'b0, gate_hi & gate_lo}, 8'h00);
        end
    endtask

    task automatic disable_test();
        @(negedge clk);
        enable = 1'b0;
        #1;
        chk("R8 gates off at disable hi", {5'b0, gate_hi}, 8'h00);
        chk("R8 gates off at disable lo", {5'b0, gate_lo}, 8'h00);
        @(negedge clk);
        #1;
        chk("R8 pattern rewound", {5'b0, leg_state}, 8'h04);
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
        #1;
        chk("R8 tick ignored", {5'b0, leg_state}, 8'h04);
        chk("R8 gates stay off", {2'b0, gate_hi, gate_lo}, 8'h00);
        pos = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        enable    = 1'b0;
        step_tick = 1'b0;
        reverse   = 1'b0;
        dead_time = '0;
        do_reset();

        foreach (int_dts[k]) begin end
        for (int k = 0; k < 3; k++) begin
            int d;
            d = (k == 0) ? 0 : ((k == 1) ? 2 : 5);
            start_run(d);
            for (int s = 0; s < 13; s++) do_step(1'b0, d);
            for (int s = 0; s < 8; s++)  do_step(1'b1, d);
            do_step(1'b0, d);
            do_step(1'b1, d);
            do_step(1'b1, d);
            disable_test();
        end

        // Reset in the middle of a run
        start_run(1);
        do_step(1'b0, 1);
        do_step(1'b0, 1);
        @(negedge clk);
        do_reset();
        chk("R9 gates after reset", {2'b0, gate_hi, gate_lo}, 8'h00);
        enable = 1'b0;
        start_run(3);
        do_step(1'b1, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int int_dts[1];

endmodule